// File: doc/BRIEF.md
# Integer rank-k update unit

This block performs a packed-integer rank-k update on a 4×4 matrix of signed 32-bit elements. Two 128-bit operands, X and Y, each hold four 32-bit rows. Each row packs k signed narrow integers. The unit forms the product of X and the transpose of Y. In accumulate mode it also adds the incoming accumulator value, and the result is returned as one 512-bit accumulator word. The element width is 16, 8 or 4 bits, which gives a rank k of 2, 4 or 8.

The surrounding datapath reads the target accumulator and the two source registers. It presents them with a one-cycle valid strobe and writes back the output when the done strobe appears. The surrounding datapath must keep the source registers apart from the target accumulator's storage. After a write-back, the target accumulator counts as loaded. A new operation can be issued on every cycle.

Inside, a four-state occupancy controller tracks the pipeline:

- IDLE: both stages are empty.
- FILL: only the first stage holds an operation.
- FULL: both stages hold an operation.
- DRAIN: only the second stage holds an operation.

The transitions are:

- IDLE goes to FILL on valid and stays in IDLE otherwise.
- FILL goes to FULL on valid and to DRAIN otherwise.
- FULL stays in FULL on valid and goes to DRAIN otherwise.
- DRAIN goes to FILL on valid and to IDLE otherwise.

Top module: `int_rank_update`

## Requirements
- R1: While rst_n is low and after its release, done is 0 and acc_out is all zeros until the first operation completes.
- R2: An operation whose op_valid is sampled at clock edge N raises done for exactly the cycle after edge N+1, so done follows valid by two cycles. Operations issued on consecutive cycles complete on consecutive cycles.
- R3: op_wsel = 0 selects 16-bit elements with k = 2. Element p of row r sits at bits [32r+16p+15 : 32r+16p].
- R4: op_wsel = 1 selects 8-bit elements with k = 4. Element p of row r sits at bits [32r+8p+7 : 32r+8p].
- R5: op_wsel = 2 selects 4-bit elements with k = 8. Element p of row r sits at bits [32r+4p+3 : 32r+4p].
- R6: op_wsel = 3 behaves exactly like op_wsel = 0.
- R7: With op_accum = 1, each result element equals the old acc_in element plus the sum over p of X[i][p]·Y[j][p]. All narrow elements are treated as signed.
- R8: With op_accum = 0, acc_in has no effect, and the result is the product sum alone.
- R9: All sums wrap modulo 2^32 with no saturation.
- R10: acc_out changes only in a cycle where done is 1, and holds its value otherwise.
- R11: Result element (i,j) sits at acc_out bits [128i+32j+31 : 128i+32j]. It is formed from X row i and Y row j. acc_in uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe, one cycle per operation |
| op_wsel | input | 2 | Element width code: 0=16 bit, 1=8 bit, 2=4 bit, 3=16 bit |
| op_accum | input | 1 | 1 adds the old accumulator value into the result |
| x_opnd | input | 128 | Operand X, four packed rows |
| y_opnd | input | 128 | Operand Y, four packed rows |
| acc_in | input | 512 | Current accumulator value |
| acc_out | output | 512 | Updated accumulator value |
| done | output | 1 | Result valid strobe |

## Verification
A controller stuck in the wrong occupancy state shows up at the done port within two cycles. The strobe is then missing, doubled or late relative to the valid that caused it. A wrong width decode or a swapped lane index corrupts acc_out in the very cycle done rises. Single-bit operands that hit one matrix position make a swapped row or column show up as one misplaced 32-bit word. An accumulate path that leaks old data when it should not is caught by reloading with op_accum low over a nonzero acc_in. A stage register that loads outside its slot changes acc_out in a cycle with done low.

// File: rtl/irk_pkg.sv
package irk_pkg;

    typedef enum logic [1:0] {
        WSEL_16  = 2'd0,
        WSEL_8   = 2'd1,
        WSEL_4   = 2'd2,
        WSEL_ALT = 2'd3
    } wsel_e;

    // Pipeline occupancy: {stage1 full, stage2 full}
    typedef enum logic [1:0] {
        CT_IDLE  = 2'b00,
        CT_FILL  = 2'b10,
        CT_FULL  = 2'b11,
        CT_DRAIN = 2'b01
    } ctrl_state_e;

endpackage

// File: rtl/irk_lane.sv
// Dot product of two packed rows for one fixed narrow element width.
module irk_lane #(
    parameter int ELEM_W = 32,
    parameter int NARROW = 16
) (
    input  logic [ELEM_W-1:0] xrow,
    input  logic [ELEM_W-1:0] yrow,
    output logic [ELEM_W-1:0] dot
);
    localparam int K = ELEM_W / NARROW;

    logic [ELEM_W-1:0] prod [K];

    generate
        for (genvar p = 0; p < K; p++) begin : g_prod
            logic signed [ELEM_W-1:0] xs;
            logic signed [ELEM_W-1:0] ys;
            assign xs = ELEM_W'($signed(xrow[NARROW*p +: NARROW]));
            assign ys = ELEM_W'($signed(yrow[NARROW*p +: NARROW]));
            assign prod[p] = xs * ys;
        end
    endgenerate

    always_comb begin
        dot = '0;
        for (int p = 0; p < K; p++) begin
            dot = dot + prod[p];
        end
    end
endmodule

// File: rtl/irk_dot.sv
// One matrix element: three width lanes and a width select.
module irk_dot #(
    parameter int ELEM_W = 32
) (
    input  logic [ELEM_W-1:0] xrow,
    input  logic [ELEM_W-1:0] yrow,
    input  irk_pkg::wsel_e    wsel,
    output logic [ELEM_W-1:0] dot
);
    import irk_pkg::*;

    logic [ELEM_W-1:0] d16;
    logic [ELEM_W-1:0] d8;
    logic [ELEM_W-1:0] d4;

    irk_lane #(.ELEM_W(ELEM_W), .NARROW(16)) u_l16 (.xrow(xrow), .yrow(yrow), .dot(d16));
    irk_lane #(.ELEM_W(ELEM_W), .NARROW(8))  u_l8  (.xrow(xrow), .yrow(yrow), .dot(d8));
    irk_lane #(.ELEM_W(ELEM_W), .NARROW(4))  u_l4  (.xrow(xrow), .yrow(yrow), .dot(d4));

    always_comb begin
        unique case (wsel)
            WSEL_8:  dot = d8;
            WSEL_4:  dot = d4;
            default: dot = d16;
        endcase
    end
endmodule

// File: rtl/irk_ctrl.sv
// Occupancy controller for the two-stage pipeline.
module irk_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    output logic s2_load,
    output logic done
);
    import irk_pkg::*;

    ctrl_state_e state;
    ctrl_state_e state_nx;

    always_comb begin
        unique case (state)
            CT_IDLE:  state_nx = valid ? CT_FILL : CT_IDLE;
            CT_FILL:  state_nx = valid ? CT_FULL : CT_DRAIN;
            CT_FULL:  state_nx = valid ? CT_FULL : CT_DRAIN;
            CT_DRAIN: state_nx = valid ? CT_FILL : CT_IDLE;
            default:  state_nx = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CT_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            CT_IDLE:  begin s2_load = 1'b0; done = 1'b0; end
            CT_FILL:  begin s2_load = 1'b1; done = 1'b0; end
            CT_FULL:  begin s2_load = 1'b1; done = 1'b1; end
            CT_DRAIN: begin s2_load = 1'b0; done = 1'b1; end
            default:  begin s2_load = 1'b0; done = 1'b0; end
        endcase
    end
endmodule

// File: rtl/int_rank_update.sv
module int_rank_update #(
    parameter int ELEM_W = 32,
    parameter int DIM    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [1:0]                  op_wsel,
    input  logic                        op_accum,
    input  logic [DIM*ELEM_W-1:0]       x_opnd,
    input  logic [DIM*ELEM_W-1:0]       y_opnd,
    input  logic [DIM*DIM*ELEM_W-1:0]   acc_in,
    output logic [DIM*DIM*ELEM_W-1:0]   acc_out,
    output logic                        done
);
    import irk_pkg::*;

    localparam int CELLS = DIM * DIM;

    wsel_e wsel;
    logic  s2_load;

    assign wsel = wsel_e'(op_wsel);

    irk_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (op_valid),
        .s2_load (s2_load),
        .done    (done)
    );

    logic [ELEM_W-1:0] s1_dot [CELLS];
    logic [ELEM_W-1:0] s1_add [CELLS];

    generate
        for (genvar i = 0; i < DIM; i++) begin : g_row
            for (genvar j = 0; j < DIM; j++) begin : g_col
                localparam int C = i * DIM + j;
                logic [ELEM_W-1:0] dot_c;

                irk_dot #(.ELEM_W(ELEM_W)) u_dot (
                    .xrow (x_opnd[ELEM_W*i +: ELEM_W]),
                    .yrow (y_opnd[ELEM_W*j +: ELEM_W]),
                    .wsel (wsel),
                    .dot  (dot_c)
                );

                // Stage 1: product sums and the masked addend
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        s1_dot[C] <= '0;
                        s1_add[C] <= '0;
                    end else if (op_valid) begin
                        s1_dot[C] <= dot_c;
                        s1_add[C] <= op_accum ? acc_in[ELEM_W*C +: ELEM_W] : '0;
                    end
                end

                // Stage 2: final add
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)       acc_out[ELEM_W*C +: ELEM_W] <= '0;
                    else if (s2_load) acc_out[ELEM_W*C +: ELEM_W] <= s1_dot[C] + s1_add[C];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/irk_chk.sv
module irk_chk #(
    parameter int ACC_W = 512,
    parameter int X_W   = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic             op_accum,
    input logic [X_W-1:0]   x_opnd,
    input logic [ACC_W-1:0] acc_in,
    input logic [ACC_W-1:0] acc_out,
    input logic             done
);
    logic             v1, v2;
    logic             zx1, zx2;
    logic             ac1, ac2;
    logic [ACC_W-1:0] a1, a2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0;
            zx1 <= 1'b0; zx2 <= 1'b0;
            ac1 <= 1'b0; ac2 <= 1'b0;
            a1 <= '0; a2 <= '0;
        end else begin
            v1  <= op_valid;          v2  <= v1;
            zx1 <= (x_opnd == '0);    zx2 <= zx1;
            ac1 <= op_accum;          ac2 <= ac1;
            a1  <= acc_in;            a2  <= a1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && acc_out == '0));

    assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done == v2);

    assert_accum_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && v2 && zx2 && ac2) |-> acc_out == a2);

    assert_ignore_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && v2 && zx2 && !ac2) |-> acc_out == '0);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_out) |-> done);
endmodule

bind int_rank_update irk_chk #(.ACC_W(512), .X_W(128)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_accum (op_accum),
    .x_opnd   (x_opnd),
    .acc_in   (acc_in),
    .acc_out  (acc_out),
    .done     (done)
);

// File: tb/sim_int_rank_update.sv
`timescale 1ns/1ps
module sim_int_rank_update;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   op_wsel = 2'd0;
    logic         op_accum = 1'b0;
    logic [127:0] x_opnd = '0;
    logic [127:0] y_opnd = '0;
    logic [511:0] acc_in = '0;
    logic [511:0] acc_out;
    logic         done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    int_rank_update u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_wsel(op_wsel),
        .op_accum(op_accum), .x_opnd(x_opnd), .y_opnd(y_opnd),
        .acc_in(acc_in), .acc_out(acc_out), .done(done)
    );

    function automatic logic signed [31:0] sx(input logic [127:0] v, input int lsb, input int nw);
        logic [31:0] t;
        t = 32'(v >> lsb);
        t = t << (32 - nw);
        return $signed(t) >>> (32 - nw);
    endfunction

    function automatic logic [511:0] model(input logic [127:0] x, input logic [127:0] y,
                                           input logic [511:0] a, input logic [1:0] w,
                                           input logic en);
        logic [511:0] r;
        int nw;
        int k;
        r  = '0;
        nw = (w == 2'd1) ? 8 : (w == 2'd2) ? 4 : 16;
        k  = 32 / nw;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic [31:0] s;
                s = en ? a[128*i+32*j +: 32] : 32'd0;
                for (int p = 0; p < k; p++)
                    s = s + 32'(sx(x, 32*i + nw*p, nw) * sx(y, 32*j + nw*p, nw));
                r[128*i+32*j +: 32] = s;
            end
        end
        return r;
    endfunction

    task automatic check(input logic ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [127:0] x, input logic [127:0] y, input logic [511:0] a,
                         input logic [1:0] w, input logic en);
        op_valid = 1'b1; x_opnd = x; y_opnd = y; acc_in = a; op_wsel = w; op_accum = en;
    endtask

    // Single op: issue at a negedge, result seen at the second negedge after.
    task automatic single(input logic [127:0] x, input logic [127:0] y, input logic [511:0] a,
                          input logic [1:0] w, input logic en, input logic [511:0] exp, input string req);
        @(negedge clk); drive(x, y, a, w, en);
        @(negedge clk); op_valid = 1'b0;
        check(done == 1'b0, "R2 early", 512'(done), 512'(0));
        @(negedge clk);
        check(done == 1'b1, "R2 done", 512'(done), 512'(1));
        check(acc_out == exp, req, acc_out, exp);
        @(negedge clk);
        check(done == 1'b0, "R2 single pulse", 512'(done), 512'(0));
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [511:0] rnd512();
        return {rnd128(), rnd128(), rnd128(), rnd128()};
    endfunction

    task automatic test_reset();
        check(done == 1'b0, "R1 done in reset", 512'(done), 512'(0));
        check(acc_out == '0, "R1 acc in reset", acc_out, '0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && acc_out == '0, "R1 after release", acc_out, '0);
    endtask

    task automatic test_layout();
        logic [127:0] x;
        logic [127:0] y;
        // X row 1 elem 0 = 1, Y row 2 elem 0 = 1 -> only (1,2) = 1 at bit 128+64
        x = 128'(1) << 32; y = 128'(1) << 64;
        single(x, y, '0, 2'd0, 1'b0, 512'(1) << 192, "R11 layout");
    endtask

    task automatic test_widths();
        for (int n = 0; n < 3; n++) begin
            logic [127:0] x;
            logic [127:0] y;
            x = rnd128(); y = rnd128();
            single(x, y, '0, 2'd0, 1'b0, model(x, y, '0, 2'd0, 1'b0), "R3 16-bit");
            single(x, y, '0, 2'd1, 1'b0, model(x, y, '0, 2'd1, 1'b0), "R4 8-bit");
            single(x, y, '0, 2'd2, 1'b0, model(x, y, '0, 2'd2, 1'b0), "R5 4-bit");
        end
        // 4-bit: all -8 times -8, k=8 -> 8*64 = 512 per element
        single({32{4'h8}}, {32{4'h8}}, '0, 2'd2, 1'b0, {16{32'd512}}, "R5 4-bit extremes");
        // 8-bit: -1 times 1, k=4 -> -4
        single({16{8'hFF}}, {16{8'h01}}, '0, 2'd1, 1'b0, {16{32'hFFFF_FFFC}}, "R4 8-bit sign");
    endtask

    task automatic test_alt_code();
        logic [127:0] x;
        logic [127:0] y;
        x = rnd128(); y = rnd128();
        single(x, y, '0, 2'd3, 1'b0, model(x, y, '0, 2'd0, 1'b0), "R6 code 3");
    endtask

    task automatic test_accum();
        logic [127:0] x;
        logic [127:0] y;
        logic [511:0] a;
        x = rnd128(); y = rnd128(); a = rnd512();
        single(x, y, a, 2'd1, 1'b1, model(x, y, a, 2'd1, 1'b1), "R7 accumulate");
        single('0, y, a, 2'd0, 1'b1, a, "R7 zero X keeps old");
    endtask

    task automatic test_ignore();
        logic [127:0] x;
        logic [127:0] y;
        x = rnd128(); y = rnd128();
        single(x, y, {16{32'hDEAD_BEEF}}, 2'd2, 1'b0, model(x, y, '0, 2'd2, 1'b0), "R8 old ignored");
        single('0, y, rnd512(), 2'd0, 1'b0, '0, "R8 zero result");
    endtask

    task automatic test_wrap();
        // 16-bit: (-32768)^2 * 2 = 2^31 -> 0x80000000
        single({8{16'h8000}}, {8{16'h8000}}, '0, 2'd0, 1'b0, {16{32'h8000_0000}}, "R9 product wrap");
        // 0x7FFFFFFF + 1 -> 0x80000000
        single({4{32'h0000_0001}}, {4{32'h0000_0001}}, {16{32'h7FFF_FFFF}}, 2'd0, 1'b1,
               {16{32'h8000_0000}}, "R9 accumulate wrap");
    endtask

    task automatic test_back_to_back();
        logic [127:0] xs [3];
        logic [127:0] ys [3];
        logic [511:0] as [3];
        for (int n = 0; n < 3; n++) begin xs[n] = rnd128(); ys[n] = rnd128(); as[n] = rnd512(); end
        @(negedge clk); drive(xs[0], ys[0], as[0], 2'd0, 1'b1);
        @(negedge clk); drive(xs[1], ys[1], as[1], 2'd1, 1'b0);
        @(negedge clk); drive(xs[2], ys[2], as[2], 2'd2, 1'b1);
        check(done == 1'b1, "R2 b2b done0", 512'(done), 512'(1));
        check(acc_out == model(xs[0], ys[0], as[0], 2'd0, 1'b1), "R2 b2b op0", acc_out, model(xs[0], ys[0], as[0], 2'd0, 1'b1));
        @(negedge clk); op_valid = 1'b0;
        check(done == 1'b1, "R2 b2b done1", 512'(done), 512'(1));
        check(acc_out == model(xs[1], ys[1], as[1], 2'd1, 1'b0), "R2 b2b op1", acc_out, model(xs[1], ys[1], as[1], 2'd1, 1'b0));
        @(negedge clk);
        check(done == 1'b1, "R2 b2b done2", 512'(done), 512'(1));
        check(acc_out == model(xs[2], ys[2], as[2], 2'd2, 1'b1), "R2 b2b op2", acc_out, model(xs[2], ys[2], as[2], 2'd2, 1'b1));
        @(negedge clk);
        check(done == 1'b0, "R2 b2b end", 512'(done), 512'(0));
    endtask

    task automatic test_hold();
        logic [511:0] last;
        last = acc_out;
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            x_opnd = rnd128(); y_opnd = rnd128(); acc_in = rnd512(); op_accum = n[0];
            check(done == 1'b0 && acc_out == last, "R10 hold", acc_out, last);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        test_reset();
        test_layout();
        test_widths();
        test_alt_code();
        test_accum();
        test_ignore();
        test_wrap();
        test_back_to_back();
        test_hold();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule